// File: doc/BRIEF.md
# Segmented Virtual Address Relocation Unit

This unit sits between a processor and its memory bus and turns a 16-bit virtual address into an 18-bit physical address. The top three virtual address bits pick one of eight segments. The segment's descriptor comes from a bank chosen by the current protection mode (kernel, supervisor or user) and by the access kind (instruction fetch or data access), so every mode has its own instruction space and its own data space. The descriptor holds three things: a base in 64-byte units, a length in 64-byte blocks, and an access-control code. The physical address is the base placed six bits up, plus the 13-bit offset inside the segment.

A request enters on a valid/ready handshake, and the result leaves on a second valid/ready handshake in the same cycle. The path is combinational, with no storage in it. Back-pressure rules: a translated request is accepted (`in_ready` high) only when the consumer is ready (`out_ready`). A request that faults raises `out_abort` instead of `out_valid` and is always accepted at once, whatever `out_ready` is. Descriptors and a global enable bit are written and read back through a synchronous programming port. While the enable bit is clear, addresses pass through untranslated and unchecked. In that state the top 8 KB of the virtual space is steered to the top 8 KB of the physical space, where device registers live.

Top module: `seg_relocate`

## Requirements
- R1: A synchronous reset clears the enable bit and sets every access-control code to no access (00). After reset, an enabled access to any segment that has not been programmed aborts.
- R2: With the enable bit clear, a request is never aborted. Any address below 0xE000 comes out zero-extended to 18 bits.
- R3: With the enable bit clear, an address in 0xE000 to 0xFFFF maps to 0x3E000 plus its low 13 bits.
- R4: With the enable bit set and no fault, the physical address is (base × 64 + vaddr[12:0]) modulo 2^18.
- R5: The descriptor used is chosen by the mode (0 kernel, 1 supervisor, 2 user), the space (`in_instr` = 1 instruction, 0 data) and vaddr[15:13]. Programming one bank leaves the other banks unaffected.
- R6: With the enable bit set, the request aborts when the block number vaddr[12:6] is greater than the length field. The length field is the highest legal block.
- R7: Access-control codes: 00 aborts every access, 01 allows reads and aborts writes, 11 allows reads and writes, and 10 behaves as 00.
- R8: With the enable bit set, mode value 3 aborts every access.
- R9: `out_valid` = `in_valid` and not abort. `out_abort` rises only with `in_valid`. `in_ready` equals `out_ready` for a request that translates, and is 1 for a request that aborts.
- R10: Programming address layout is {mode[1:0], space, segment[2:0], field[1:0]}. The field codes are: 0 base (12 bits), 1 length (7 bits), 2 access control (2 bits), and 3 control (bit 0 = enable, the other address bits are ignored). `cfg_rdata` returns the addressed field zero-extended. Writes to mode 3 descriptors are dropped, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Translation request present |
| in_ready | output | 1 | Request accepted this cycle |
| in_vaddr | input | 16 | Virtual address |
| in_instr | input | 1 | 1 = instruction fetch, 0 = data access |
| in_write | input | 1 | 1 = write, 0 = read |
| in_mode | input | 2 | Protection mode: 0 kernel, 1 supervisor, 2 user |
| out_valid | output | 1 | Translated address valid |
| out_ready | input | 1 | Consumer can take the address |
| out_paddr | output | 18 | Physical address |
| out_abort | output | 1 | Request faulted |
| cfg_we | input | 1 | Programming write strobe |
| cfg_addr | input | 8 | Programming address |
| cfg_wdata | input | 16 | Programming write data |
| cfg_rdata | output | 16 | Programming read data |

## Verification
The hardest case to reach is a base near the top of physical memory combined with an offset that carries past 2^18, together with a length field sitting exactly at the block being accessed. Both the wrap and the off-by-one bound must be seen in one bank. The stimulus gets there by programming a user data segment with base 0xFFF and length 10. It then issues a read at block 10, which must wrap, and another read at block 11, which must abort. The same virtual address is also driven in other modes and spaces to show that the neighbouring banks stay unprogrammed.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_RO   = 2'b01,
    ACC_RSVD = 2'b10,
    ACC_RW   = 2'b11
  } seg_acc_e;

  typedef enum logic [1:0] {
    FLD_BASE = 2'd0,
    FLD_LEN  = 2'd1,
    FLD_ACC  = 2'd2,
    FLD_CTRL = 2'd3
  } seg_fld_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_pkg::*;
#(
  parameter int SEG_W   = 3,
  parameter int BASE_W  = 12,
  parameter int LEN_W   = 7,
  parameter int N_MODES = 3,
  parameter int CFG_DW  = 16,
  localparam int CFG_AW = SEG_W + 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  output logic              xl_enable,
  input  logic [1:0]        lk_mode,
  input  logic              lk_space,
  input  logic [SEG_W-1:0]  lk_seg,
  output logic              lk_mode_ok,
  output logic [BASE_W-1:0] lk_base,
  output logic [LEN_W-1:0]  lk_len,
  output seg_acc_e          lk_acc
);
  localparam int NSEG = 1 << SEG_W;
  localparam int NENT = N_MODES * 2 * NSEG;
  localparam int IW   = $clog2(NENT);

  logic [BASE_W-1:0] base_q [NENT];
  logic [LEN_W-1:0]  len_q  [NENT];
  seg_acc_e          acc_q  [NENT];
  logic              en_q;

  function automatic logic [IW-1:0] ent_idx(input logic [1:0] m, input logic s,
                                            input logic [SEG_W-1:0] g);
    int v;
    v = ((int'(m) * 2) + int'(s)) * NSEG + int'(g);
    return IW'(v);
  endfunction

  seg_fld_e          c_fld;
  logic [SEG_W-1:0]  c_seg;
  logic              c_space;
  logic [1:0]        c_mode;
  logic              c_ok;
  logic [IW-1:0]     c_idx;
  logic [IW-1:0]     l_idx;

  assign c_fld   = seg_fld_e'(cfg_addr[1:0]);
  assign c_seg   = cfg_addr[SEG_W+1:2];
  assign c_space = cfg_addr[SEG_W+2];
  assign c_mode  = cfg_addr[SEG_W+4:SEG_W+3];
  assign c_ok    = int'(c_mode) < N_MODES;
  assign c_idx   = c_ok ? ent_idx(c_mode, c_space, c_seg) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
      for (int i = 0; i < NENT; i++) begin
        base_q[i] <= '0;
        len_q[i]  <= '0;
        acc_q[i]  <= ACC_NONE;
      end
    end else if (cfg_we) begin
      case (c_fld)
        FLD_CTRL: en_q <= cfg_wdata[0];
        FLD_BASE: if (c_ok) base_q[c_idx] <= cfg_wdata[BASE_W-1:0];
        FLD_LEN:  if (c_ok) len_q[c_idx]  <= cfg_wdata[LEN_W-1:0];
        default:  if (c_ok) acc_q[c_idx]  <= seg_acc_e'(cfg_wdata[1:0]);
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (c_fld)
      FLD_CTRL: cfg_rdata[0] = en_q;
      FLD_BASE: if (c_ok) cfg_rdata[BASE_W-1:0] = base_q[c_idx];
      FLD_LEN:  if (c_ok) cfg_rdata[LEN_W-1:0]  = len_q[c_idx];
      default:  if (c_ok) cfg_rdata[1:0]        = acc_q[c_idx];
    endcase
  end

  assign xl_enable  = en_q;
  assign lk_mode_ok = int'(lk_mode) < N_MODES;
  assign l_idx      = lk_mode_ok ? ent_idx(lk_mode, lk_space, lk_seg) : '0;
  assign lk_base    = base_q[l_idx];
  assign lk_len     = len_q[l_idx];
  assign lk_acc     = acc_q[l_idx];

  // R10: a control write lands in the enable bit one edge later
  a_r10_ctrl_write: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr[1:0] == 2'd3) |=> (xl_enable == $past(cfg_wdata[0])));
endmodule

// File: rtl/seg_guard.sv
module seg_guard
  import seg_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic             enable,
  input  logic             mode_ok,
  input  seg_acc_e         acc,
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] blk,
  input  logic             is_write,
  output logic             fault
);
  logic acc_fault;
  logic len_fault;

  always_comb begin
    case (acc)
      ACC_RW:  acc_fault = 1'b0;
      ACC_RO:  acc_fault = is_write;
      default: acc_fault = 1'b1;
    endcase
  end

  assign len_fault = blk > len;
  assign fault     = enable && (!mode_ok || acc_fault || len_fault);
endmodule

// File: rtl/seg_addr_form.sv
module seg_addr_form #(
  parameter int VA_W      = 16,
  parameter int PA_W      = 18,
  parameter int SEG_W     = 3,
  parameter int BLK_SHIFT = 6,
  parameter int BASE_W    = 12,
  localparam int OFF_W    = VA_W - SEG_W
) (
  input  logic              enable,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [BASE_W-1:0] base,
  output logic [PA_W-1:0]   paddr
);
  logic [PA_W-1:0] reloc;
  logic [PA_W-1:0] bypass;
  logic            io_win;

  assign reloc  = PA_W'({base, {BLK_SHIFT{1'b0}}}) + PA_W'(vaddr[OFF_W-1:0]);
  assign io_win = &vaddr[VA_W-1:OFF_W];

  generate
    if (PA_W > VA_W) begin : g_wide
      assign bypass = io_win ? {{(PA_W-OFF_W){1'b1}}, vaddr[OFF_W-1:0]}
                             : {{(PA_W-VA_W){1'b0}}, vaddr};
    end else begin : g_narrow
      assign bypass = PA_W'(vaddr);
    end
  endgenerate

  assign paddr = enable ? reloc : bypass;
endmodule

// File: rtl/seg_relocate.sv
module seg_relocate
  import seg_pkg::*;
#(
  parameter int VA_W      = 16,
  parameter int PA_W      = 18,
  parameter int SEG_W     = 3,
  parameter int BLK_SHIFT = 6,
  parameter int BASE_W    = 12,
  parameter int N_MODES   = 3,
  parameter int CFG_DW    = 16,
  localparam int OFF_W    = VA_W - SEG_W,
  localparam int LEN_W    = OFF_W - BLK_SHIFT,
  localparam int CFG_AW   = SEG_W + 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VA_W-1:0]   in_vaddr,
  input  logic              in_instr,
  input  logic              in_write,
  input  logic [1:0]        in_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PA_W-1:0]   out_paddr,
  output logic              out_abort,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata
);
  logic              enable;
  logic              mode_ok;
  logic [BASE_W-1:0] seg_base;
  logic [LEN_W-1:0]  seg_len;
  seg_acc_e          seg_acc;
  logic              fault;
  logic [LEN_W-1:0]  blk;

  assign blk = in_vaddr[OFF_W-1:BLK_SHIFT];

  seg_regfile #(
    .SEG_W(SEG_W), .BASE_W(BASE_W), .LEN_W(LEN_W),
    .N_MODES(N_MODES), .CFG_DW(CFG_DW)
  ) u_regs (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .xl_enable(enable),
    .lk_mode(in_mode), .lk_space(in_instr), .lk_seg(in_vaddr[VA_W-1:OFF_W]),
    .lk_mode_ok(mode_ok), .lk_base(seg_base), .lk_len(seg_len), .lk_acc(seg_acc)
  );

  seg_guard #(.LEN_W(LEN_W)) u_guard (
    .enable(enable), .mode_ok(mode_ok), .acc(seg_acc), .len(seg_len),
    .blk(blk), .is_write(in_write), .fault(fault)
  );

  seg_addr_form #(
    .VA_W(VA_W), .PA_W(PA_W), .SEG_W(SEG_W), .BLK_SHIFT(BLK_SHIFT), .BASE_W(BASE_W)
  ) u_form (
    .enable(enable), .vaddr(in_vaddr), .base(seg_base), .paddr(out_paddr)
  );

  assign out_abort = in_valid && fault;
  assign out_valid = in_valid && !fault;
  assign in_ready  = fault ? 1'b1 : out_ready;

  // R9: never both a result and an abort
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_abort));
  // R9: a translating request waits for the consumer
  a_r9_backpressure: assert property (@(posedge clk) disable iff (rst)
    (out_valid) |-> (in_ready == out_ready));
  // R2: translation off means no fault
  a_r2_bypass_no_abort: assert property (@(posedge clk) disable iff (rst)
    !enable |-> !out_abort);
  // R3: device window lands at the top of physical space
  a_r3_io_window: assert property (@(posedge clk) disable iff (rst)
    (!enable && (&in_vaddr[VA_W-1:OFF_W])) |-> (&out_paddr[PA_W-1:OFF_W]));
  // R6: offset beyond the segment length aborts
  a_r6_length: assert property (@(posedge clk) disable iff (rst)
    (in_valid && enable && (blk > seg_len)) |-> out_abort);
  // R8: the unused mode code always aborts when translating
  a_r8_bad_mode: assert property (@(posedge clk) disable iff (rst)
    (in_valid && enable && in_mode == 2'd3) |-> out_abort);
endmodule

// File: tb/sim_seg_relocate.sv
`timescale 1ns/1ps
module sim_seg_relocate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_instr = 1'b0, in_write = 1'b0, out_ready = 1'b1;
  logic [15:0] in_vaddr = '0;
  logic [1:0]  in_mode = '0;
  logic        in_ready, out_valid, out_abort;
  logic [17:0] out_paddr;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;

  always #2 clk = ~clk;

  seg_relocate u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_vaddr(in_vaddr),
    .in_instr(in_instr), .in_write(in_write), .in_mode(in_mode), .out_valid(out_valid),
    .out_ready(out_ready), .out_paddr(out_paddr), .out_abort(out_abort),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic        valid;
    logic        abort;
    logic        ready;
    logic [17:0] pa;
    string       tag;
  } exp_t;
  exp_t sb[$];
  event mon_ev;

  // shadow model of descriptors, index (mode*2+space)*8+seg
  logic [11:0] m_base [48];
  logic [6:0]  m_len  [48];
  logic [1:0]  m_acc  [48];
  logic        m_en;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_en = 1'b0;
    for (int i = 0; i < 48; i++) begin
      m_base[i] = '0; m_len[i] = '0; m_acc[i] = 2'b00;
    end
  endtask

  task automatic cfg_wr(input logic [1:0] m, input logic s, input logic [2:0] g,
                        input logic [1:0] f, input logic [15:0] d);
    int i;
    @(negedge clk);
    cfg_addr = {m, s, g, f}; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    i = (int'(m) * 2 + int'(s)) * 8 + int'(g);
    if (f == 2'd3) m_en = d[0];
    else if (m != 2'd3) begin
      if (f == 2'd0) m_base[i] = d[11:0];
      else if (f == 2'd1) m_len[i] = d[6:0];
      else m_acc[i] = d[1:0];
    end
  endtask

  task automatic cfg_chk(input logic [1:0] m, input logic s, input logic [2:0] g,
                         input logic [1:0] f, input logic [15:0] e, input string tag);
    @(negedge clk);
    cfg_addr = {m, s, g, f};
    #1;
    chk(cfg_rdata == e, tag, 32'(cfg_rdata), 32'(e));
  endtask

  // driver: compute expectation from requirements, push, present stimulus
  task automatic xlate(input logic [15:0] va, input logic ins, input logic wr,
                       input logic [1:0] m, input logic rdy, input logic vld, input string tag);
    exp_t e;
    logic flt;
    int i;
    logic [1:0] a;
    flt = 1'b0;
    if (!m_en) begin
      e.pa = (va[15:13] == 3'b111) ? {5'b11111, va[12:0]} : {2'b00, va};
    end else begin
      i = (int'(m) * 2 + int'(ins)) * 8 + int'(va[15:13]);
      if (m == 2'd3) flt = 1'b1;
      else begin
        a = m_acc[i];
        if (a == 2'b00 || a == 2'b10) flt = 1'b1;
        if (a == 2'b01 && wr) flt = 1'b1;
        if (va[12:6] > m_len[i]) flt = 1'b1;
        e.pa = 18'((int'(m_base[i]) * 64 + int'(va[12:0])) % 262144);
      end
    end
    e.valid = vld && !flt;
    e.abort = vld && flt;
    e.ready = flt ? 1'b1 : rdy;
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    in_vaddr = va; in_instr = ins; in_write = wr; in_mode = m;
    out_ready = rdy; in_valid = vld;
    #1;
    ->mon_ev;
  endtask

  // monitor: pop and compare
  initial begin
    forever begin
      exp_t e;
      @(mon_ev);
      e = sb.pop_front();
      chk(out_valid == e.valid && out_abort == e.abort && in_ready == e.ready,
          {e.tag, " flags{valid,abort,ready}"},
          32'({out_valid, out_abort, in_ready}), 32'({e.valid, e.abort, e.ready}));
      if (e.valid)
        chk(out_paddr == e.pa, {e.tag, " paddr"}, 32'(out_paddr), 32'(e.pa));
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state readback
    cfg_chk(2'd0, 1'b0, 3'd0, 2'd3, 16'h0000, "R1 enable cleared");
    cfg_chk(2'd2, 1'b1, 3'd7, 2'd2, 16'h0000, "R1 access none");
    // R2 / R3: bypass
    xlate(16'h1234, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, "R2 bypass low");
    xlate(16'hDFFF, 1'b1, 1'b1, 2'd3, 1'b1, 1'b1, "R2 bypass edge mode3");
    xlate(16'hE010, 1'b0, 1'b1, 2'd2, 1'b1, 1'b1, "R3 device window");
    xlate(16'hFFFF, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1, "R3 device window top");
    // R1: enabled with nothing programmed aborts
    cfg_wr(2'd0, 1'b0, 3'd0, 2'd3, 16'h0001);
    cfg_chk(2'd1, 1'b1, 3'd5, 2'd3, 16'h0001, "R10 enable readback");
    xlate(16'h0044, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, "R1 unprogrammed aborts");
    // program banks
    cfg_wr(2'd0, 1'b0, 3'd0, 2'd0, 16'h0100);
    cfg_wr(2'd0, 1'b0, 3'd0, 2'd1, 16'h007F);
    cfg_wr(2'd0, 1'b0, 3'd0, 2'd2, 16'h0003);
    cfg_wr(2'd0, 1'b1, 3'd0, 2'd0, 16'h0200);
    cfg_wr(2'd0, 1'b1, 3'd0, 2'd1, 16'h007F);
    cfg_wr(2'd0, 1'b1, 3'd0, 2'd2, 16'h0001);
    cfg_wr(2'd2, 1'b0, 3'd2, 2'd0, 16'h0FFF);
    cfg_wr(2'd2, 1'b0, 3'd2, 2'd1, 16'h000A);
    cfg_wr(2'd2, 1'b0, 3'd2, 2'd2, 16'h0003);
    cfg_wr(2'd1, 1'b0, 3'd7, 2'd0, 16'h0040);
    cfg_wr(2'd1, 1'b0, 3'd7, 2'd1, 16'h007F);
    cfg_wr(2'd1, 1'b0, 3'd7, 2'd2, 16'h0001);
    cfg_wr(2'd2, 1'b0, 3'd5, 2'd1, 16'h007F);
    cfg_wr(2'd2, 1'b0, 3'd5, 2'd2, 16'h0002);
    cfg_wr(2'd3, 1'b0, 3'd0, 2'd0, 16'h0ABC);
    // R4 / R5
    xlate(16'h0044, 1'b0, 1'b1, 2'd0, 1'b1, 1'b1, "R4 kernel data relocate");
    xlate(16'h0044, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, "R5 kernel instr space");
    xlate(16'h0044, 1'b0, 1'b0, 2'd2, 1'b1, 1'b1, "R5 user bank separate");
    xlate(16'h0044, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1, "R5 super bank separate");
    xlate(16'h4280, 1'b0, 1'b0, 2'd2, 1'b1, 1'b1, "R4 wrap at length bound");
    xlate(16'h42C0, 1'b0, 1'b0, 2'd2, 1'b1, 1'b1, "R6 length exceeded");
    xlate(16'h4280, 1'b1, 1'b0, 2'd2, 1'b1, 1'b1, "R5 user instr seg2 empty");
    // R7
    xlate(16'hF123, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1, "R7 read-only read");
    xlate(16'hF123, 1'b0, 1'b1, 2'd1, 1'b1, 1'b1, "R7 read-only write");
    xlate(16'h0010, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1, "R7 ro instr write");
    xlate(16'hA000, 1'b0, 1'b0, 2'd2, 1'b1, 1'b1, "R7 code 10 aborts");
    // R8
    xlate(16'h0044, 1'b0, 1'b0, 2'd3, 1'b1, 1'b1, "R8 mode 3 aborts");
    // R9
    xlate(16'h0044, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, "R9 backpressure holds");
    xlate(16'h42C0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b1, "R9 abort accepted stalled");
    xlate(16'h42C0, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0, "R9 idle no abort");
    // R10
    cfg_chk(2'd2, 1'b0, 3'd2, 2'd0, 16'h0FFF, "R10 base readback");
    cfg_chk(2'd2, 1'b0, 3'd2, 2'd1, 16'h000A, "R10 length readback");
    cfg_chk(2'd1, 1'b0, 3'd7, 2'd2, 16'h0001, "R10 access readback");
    cfg_chk(2'd3, 1'b0, 3'd0, 2'd0, 16'h0000, "R10 mode3 write dropped");
    // R2: disable again returns to bypass
    cfg_wr(2'd0, 1'b0, 3'd0, 2'd3, 16'h0000);
    xlate(16'h0044, 1'b0, 1'b1, 2'd3, 1'b1, 1'b1, "R2 bypass after disable");
    // R1: reset again clears state
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    model_reset();
    cfg_chk(2'd0, 1'b0, 3'd0, 2'd2, 16'h0000, "R1 access cleared by reset");
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    if (sb.size() != 0) chk(1'b0, "scoreboard drain", 32'(sb.size()), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule